// File: doc/BRIEF.md
# Dual-Enable Byte Memory Bus Controller

This block sits behind an asynchronous byte-wide memory port and turns its four control pins into clocked operations on an internal byte array. It has a write strobe (low active), a low-active select, a high-active select and a low-active output gate. A fast system clock samples every pin through a two-stage synchronizer. After synchronization the block classifies each cycle as read, write or deselected. It also produces the enable for the tristate data-bus driver.

A write window is open while the write strobe and both selects are all at their active levels. It therefore opens on whichever of the three reaches its active level last and closes on whichever leaves first. When the window closes, the address and data sampled in the last open cycle are committed to the array. A write-protect input from supply monitoring logic makes the block behave as deselected. Reads see a byte being committed in the same cycle, because the array forwards the new value.

Top module: `membus_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after reset, `dout_oe` is 0 and `mode` is 2'b00 (deselected).
- R2: When the write strobe is high, `sel_lo_n` is 0, `sel_hi` is 1 and `wprot` is 0, `mode` becomes 2'b01 (read). Outputs follow the pins sampled two rising clock edges earlier.
- R3: `mode` is 2'b10 (write) exactly when the write strobe, `sel_lo_n` and `sel_hi` are all active and `wprot` is 0. With any select inactive, `mode` is 2'b00 and no byte changes.
- R4: A write commits once the first of the three controls leaves its active level, whatever order the controls became active in. It stores the `din` and `addr` values that were present in the last cycle the window was open.
- R5: `dout_oe` is 1 only when both selects are active, `rd_oe_n` is 0, the write strobe is high and `wprot` is 0. A low write strobe clears `dout_oe` even while `rd_oe_n` is 0.
- R6: All 13 address bits take part in decoding, so each of the 8192 addresses holds its own byte. While `dout_oe` is 1, `dout` shows the byte at `addr`.
- R7: While `wprot` is 1, `mode` is 2'b00 and `dout_oe` is 0. A full write cycle made entirely under protection leaves the array unchanged.
- R8: If `wprot` rises while a write window is open, and the window then closes under protection, that write is dropped and the addressed byte keeps its old value.
- R9: A read in the same cycle that a write commits to the same address returns the newly written byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all bus pins |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en_n | input | 1 | Write strobe, active low |
| sel_lo_n | input | 1 | Chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| rd_oe_n | input | 1 | Output gate, active low |
| wprot | input | 1 | Write protect from supply monitor, active high |
| addr | input | 13 | Byte address |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data toward the bus driver (0 when not driving) |
| dout_oe | output | 1 | Enable for the tristate data driver |
| mode | output | 2 | Cycle class: 00 deselected, 01 read, 10 write |

## Verification
Commit of a closing write and the start of a read can fall in the same cycle. This happens when both selects and the output gate stay active and only the write strobe rises: in the cycle the close is seen, the block is already in read mode for the same address. The bench provokes this case directly. It samples `dout` in exactly that cycle and expects the new byte, not the old one. A bench-side model of the array judges every read value, including reads that follow writes opened and closed in random orders and writes dropped by protection.

// File: rtl/membus_pkg.sv
// Shared types for the byte memory bus controller.
// Assumes: mode encoding is visible at the top-level port as 2 bits.
package membus_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_READ  = 2'b01,
        MODE_WRITE = 2'b10
    } mode_e;
endpackage

// File: rtl/membus_sync.sv
// Multi-stage register chain used to bring asynchronous bus pins into the
// clock domain. Assumes the bus holds its pins steady for several clocks.
module membus_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the pins through STAGES registers, reloading the idle value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/membus_decode.sv
// Classifies each cycle from the synchronized pins, tracks the write window
// and issues a commit on the cycle the window is seen to close.
// Assumes: inputs are already synchronized; address and data are aligned
// with the control pins through identical synchronizer depth.
module membus_decode
    import membus_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n_s,
    input  logic              sl_n_s,
    input  logic              sh_s,
    input  logic              oe_n_s,
    input  logic              wp_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] din_s,
    output mode_e             mode,
    output logic              rd_ok,
    output logic              commit,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);
    logic selected;
    logic window;
    logic window_q;

    // Device selected when both chip selects are active and not protected.
    assign selected = !sl_n_s && sh_s && !wp_s;
    assign window   = selected && !wr_n_s;
    assign rd_ok    = selected && wr_n_s && !oe_n_s;

    // Cycle classification for the mode output.
    always_comb begin
        if (window)                mode = MODE_WRITE;
        else if (selected && wr_n_s) mode = MODE_READ;
        else                       mode = MODE_IDLE;
    end

    // Remember window state and the last address/data seen while open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            window_q <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            window_q <= window;
            if (window) begin
                cap_addr <= addr_s;
                cap_data <= din_s;
            end
        end
    end

    // Commit on the first closed cycle, unless protection caused or covers the close.
    assign commit = window_q && !window && !wp_s;
endmodule

// File: rtl/membus_array.sv
// Byte storage with one synchronous write port and an asynchronous read
// port that forwards a same-cycle write to the same address.
// Assumes: contents are not cleared by reset.
module membus_array #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wen,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a committed byte.
    always_ff @(posedge clk) begin
        if (wen) mem[waddr] <= wdata;
    end

    // Read with bypass of a write landing this cycle.
    assign rdata = (wen && (waddr == raddr)) ? wdata : mem[raddr];
endmodule

// File: rtl/membus_ctrl.sv
// Top of the byte memory bus controller: synchronizes the bus pins, decodes
// read/write/deselect, commits writes at window close, gates the data driver.
// Assumes: address and data are held stable around the write window close.
module membus_ctrl
    import membus_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              rd_oe_n,
    input  logic              wprot,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic [1:0]        mode
);
    localparam int CTL_W = 5;
    localparam int DP_W  = ADDR_W + DATA_W;
    localparam logic [CTL_W-1:0] CTL_IDLE = 5'b11010;

    logic [CTL_W-1:0]  ctl_s;
    logic [DP_W-1:0]   dp_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] din_s;
    logic              rd_ok;
    logic              commit;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic [DATA_W-1:0] rdata;
    mode_e             mode_i;

    membus_sync #(.W(CTL_W), .STAGES(SYNC_DEPTH), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({wr_en_n, sel_lo_n, sel_hi, rd_oe_n, wprot}),
        .q(ctl_s)
    );

    membus_sync #(.W(DP_W), .STAGES(SYNC_DEPTH), .RST_VAL('0)) u_dp_sync (
        .clk(clk), .rst_n(rst_n),
        .d({addr, din}),
        .q(dp_s)
    );

    assign addr_s = dp_s[DP_W-1:DATA_W];
    assign din_s  = dp_s[DATA_W-1:0];

    membus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .clk(clk), .rst_n(rst_n),
        .wr_n_s(ctl_s[4]), .sl_n_s(ctl_s[3]), .sh_s(ctl_s[2]),
        .oe_n_s(ctl_s[1]), .wp_s(ctl_s[0]),
        .addr_s(addr_s), .din_s(din_s),
        .mode(mode_i), .rd_ok(rd_ok), .commit(commit),
        .cap_addr(cap_addr), .cap_data(cap_data)
    );

    membus_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .wen(commit),
        .waddr(cap_addr), .wdata(cap_data),
        .raddr(addr_s), .rdata(rdata)
    );

    // Drive data only while the output gate is open.
    assign dout    = rd_ok ? rdata : '0;
    assign dout_oe = rd_ok;
    assign mode    = mode_i;
endmodule

// File: rtl/membus_ctrl_chk.sv
// Port-level properties for membus_ctrl, attached by bind. Uses a cycle
// counter so that no property looks back past reset.
module membus_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en_n,
    input logic       sel_lo_n,
    input logic       sel_hi,
    input logic       rd_oe_n,
    input logic       wprot,
    input logic       dout_oe,
    input logic [1:0] mode
);
    logic [1:0] cyc;

    // Count cycles since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)        cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!dout_oe && mode == 2'b00));

    // R7
    wprot_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && $past(wprot, 2)) |-> (!dout_oe && mode == 2'b00));

    // R5
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && $past(rd_oe_n, 2)) |-> !dout_oe);

    // R5
    wr_strobe_blocks_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && !$past(wr_en_n, 2)) |-> !dout_oe);

    // R3
    write_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && !$past(wr_en_n, 2) && !$past(sel_lo_n, 2)
         && $past(sel_hi, 2) && !$past(wprot, 2)) |-> (mode == 2'b10));

    // R2
    read_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && $past(wr_en_n, 2) && !$past(sel_lo_n, 2)
         && $past(sel_hi, 2) && !$past(wprot, 2)) |-> (mode == 2'b01));

    // R3
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);
endmodule

bind membus_ctrl membus_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .sel_lo_n(sel_lo_n),
    .sel_hi(sel_hi), .rd_oe_n(rd_oe_n), .wprot(wprot),
    .dout_oe(dout_oe), .mode(mode)
);

// File: tb/tb_membus_ctrl.sv
module tb_membus_ctrl;
    localparam int AW = 13;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en_n = 1'b1, sel_lo_n = 1'b1, sel_hi = 1'b0, rd_oe_n = 1'b1, wprot = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;
    logic [1:0]    mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [DW-1:0] mdl [1<<AW];

    always #10 clk = ~clk;

    membus_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .sel_lo_n(sel_lo_n),
        .sel_hi(sel_hi), .rd_oe_n(rd_oe_n), .wprot(wprot), .addr(addr),
        .din(din), .dout(dout), .dout_oe(dout_oe), .mode(mode)
    );

    function automatic logic [1:0] exp_mode(logic w, logic l, logic h, logic p);
        if (p || l || !h) return 2'b00;
        return w ? 2'b01 : 2'b10;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_idle();
        wr_en_n = 1'b1; sel_lo_n = 1'b1; sel_hi = 1'b0; rd_oe_n = 1'b1;
    endtask

    task automatic set_ctl(input int idx, input bit act);
        case (idx)
            0: wr_en_n  = !act;
            1: sel_lo_n = !act;
            default: sel_hi = act;
        endcase
    endtask

    // Open the window in a given order, close it with a chosen control.
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int first, input int second, input int closer);
        int third;
        third = 3 - first - second;
        bus_idle(); addr = a; din = d;
        @(negedge clk); set_ctl(first, 1);
        @(negedge clk); set_ctl(second, 1);
        @(negedge clk); set_ctl(third, 1);
        settle();
        chk(mode == exp_mode(0, 0, 1, wprot), "R3 write mode", mode, exp_mode(0, 0, 1, wprot));
        set_ctl(closer, 0);
        settle();
        chk(mode != 2'b10, "R4 window closed", mode, 0);
        bus_idle();
        @(negedge clk);
        if (!wprot) mdl[a] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string req);
        bus_idle(); addr = a;
        @(negedge clk);
        wr_en_n = 1'b1; sel_lo_n = 1'b0; sel_hi = 1'b1; rd_oe_n = 1'b0;
        settle();
        chk(dout_oe == 1'b1, "R5 driver on for read", dout_oe, 1);
        chk(mode == 2'b01, "R2 read mode", mode, 1);
        chk(dout == mdl[a], req, dout, mdl[a]);
        bus_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int f, s;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dout_oe == 0 && mode == 2'b00, "R1 reset outputs", {dout_oe, mode}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dout_oe == 0 && mode == 2'b00, "R1 after reset", {dout_oe, mode}, 0);

        // R6: each address bit and the extremes
        for (int k = 0; k < AW; k++) do_write(AW'(1 << k), DW'(8'h10 + k), 0, 1, 0);
        do_write('0, 8'hA5, 2, 1, 1);
        do_write('1, 8'h5A, 1, 0, 2);
        for (int k = 0; k < AW; k++) do_read(AW'(1 << k), "R6 address bit");
        do_read('0, "R6 address zero");
        do_read('1, "R6 top address");

        // R2: latency of two edges
        bus_idle(); addr = '0; @(negedge clk);
        wr_en_n = 1'b1; sel_lo_n = 1'b0; sel_hi = 1'b1; rd_oe_n = 1'b0;
        @(negedge clk);
        chk(dout_oe == 0, "R2 not yet after one edge", dout_oe, 0);
        @(negedge clk);
        chk(dout_oe == 1 && dout == mdl[0], "R2 after two edges", dout, mdl[0]);

        // R5: output gate high, and write strobe low with gate low
        rd_oe_n = 1'b1; settle();
        chk(dout_oe == 0, "R5 gate high", dout_oe, 0);
        rd_oe_n = 1'b0; wr_en_n = 1'b0; din = mdl[0]; settle();
        chk(dout_oe == 0, "R5 strobe low blocks driver", dout_oe, 0);
        chk(mode == 2'b10, "R3 write mode during strobe", mode, 2);
        bus_idle(); @(negedge clk);

        // R3: only one select active, no write
        addr = 13'h0123; din = 8'hEE;
        wr_en_n = 1'b0; sel_lo_n = 1'b0; sel_hi = 1'b0; settle();
        chk(mode == 2'b00, "R3 high select inactive", mode, 0);
        bus_idle(); @(negedge clk);
        mdl[13'h0123] = 8'h00;
        do_write(13'h0123, 8'h33, 0, 2, 1);
        wr_en_n = 1'b0; sel_lo_n = 1'b1; sel_hi = 1'b1; addr = 13'h0123; din = 8'hEE;
        settle(); bus_idle(); @(negedge clk);
        do_read(13'h0123, "R3 no write with low select inactive");

        // R4: random orders and closers
        for (int n = 0; n < 40; n++) begin
            a = AW'($urandom);
            d = DW'($urandom);
            f = $urandom % 3;
            s = (f + 1 + $urandom % 2) % 3;
            do_write(a, d, f, s, $urandom % 3);
            do_read(a, "R4 random write readback");
        end

        // R7: full write under protection, and read under protection
        do_write(13'h0777, 8'h77, 0, 1, 2);
        wprot = 1'b1; @(negedge clk);
        do_write(13'h0777, 8'h99, 1, 2, 0);
        wr_en_n = 1'b1; sel_lo_n = 1'b0; sel_hi = 1'b1; rd_oe_n = 1'b0; settle();
        chk(dout_oe == 0 && mode == 2'b00, "R7 protected read", {dout_oe, mode}, 0);
        bus_idle(); wprot = 1'b0; settle();
        do_read(13'h0777, "R7 protected write ignored");

        // R8: protection rises mid-window
        bus_idle(); addr = 13'h0777; din = 8'h42; @(negedge clk);
        wr_en_n = 1'b0; sel_lo_n = 1'b0; sel_hi = 1'b1; settle();
        wprot = 1'b1; settle();
        chk(mode == 2'b00, "R8 protected mid-window", mode, 0);
        bus_idle(); settle();
        wprot = 1'b0; settle();
        do_read(13'h0777, "R8 dropped write keeps old byte");

        // R9: same-cycle commit and read of the same address
        bus_idle(); addr = 13'h1ABC; din = 8'hC3; @(negedge clk);
        sel_lo_n = 1'b0; sel_hi = 1'b1; rd_oe_n = 1'b0; wr_en_n = 1'b0; settle();
        wr_en_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(dout_oe == 1 && dout == 8'hC3, "R9 forwarded byte", dout, 8'hC3);
        mdl[13'h1ABC] = 8'hC3;
        bus_idle(); @(negedge clk);
        do_read(13'h1ABC, "R9 byte stored");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule